// File: doc/BRIEF.md
# Trace Drain FIFO with Core Stall

This block buffers 32-bit values captured on a processor's local bus, such as execution status words and operand data, and plays them out on an 8-bit parallel trace port. Each buffered word leaves as four bytes over four clocks, most significant byte first. When nothing is buffered, the port carries a fixed idle byte. The capture side has two strobes with their own data. A read-modify-write access can therefore deliver two words in one clock, and both are taken in that clock if there is room.

A single parameter selects a two-entry or a four-entry buffer. The block raises a stall request to the core before the buffer can overflow. In the two-entry build the request rises when both entries are occupied and falls once one entry is free. In the four-entry build it rises at three occupied entries and falls once two entries are free. A word that arrives with no free slot is discarded, and a sticky flag records the loss until reset. The core is expected to honour the stall, so a correct system never sets this flag.

Top module: `trace_drain_fifo`

## Requirements
- R1: During and directly after reset the trace port shows the idle byte, and both the stall request and the overflow flag are low.
- R2: While the buffer holds no entry, the trace port shows the idle byte 8'hFF.
- R3: A word pushed into an empty buffer appears on the trace port from the clock after its push edge, as four consecutive bytes, bits [31:24] first and bits [7:0] last. The next buffered word follows with no idle byte in between.
- R4: Words leave in arrival order. When both strobes fire in one clock, the word on strobe 0 leaves before the word on strobe 1.
- R5: In the four-entry build the stall request is high from the clock edge at which three or more entries are occupied.
- R6: In the four-entry build the stall request falls at the clock edge at which occupancy drops to two entries (two free).
- R7: In the two-entry build the stall request is high while both entries are occupied and falls at the edge at which one entry becomes free.
- R8: A push that finds no free slot is discarded and leaves the buffered words unchanged. It sets the overflow flag, which stays high until reset.
- R9: Both strobes in one clock are both accepted when two slots are free. When only one slot is free, the strobe 0 word is kept and the strobe 1 word is discarded (R8 applies to it).
- R10: A slot freed by the last byte of the head word leaving in a clock can be filled by a push in that same clock without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cap0_vld | input | 1 | First capture strobe |
| cap0_data | input | 32 | First captured word |
| cap1_vld | input | 1 | Second capture strobe, same clock as the first |
| cap1_data | input | 32 | Second captured word |
| trace_out | output | 8 | Trace byte, idle code when empty |
| core_stall | output | 1 | Stall request to the core |
| ovf_flag | output | 1 | Sticky lost-word indicator |

## Verification
Two functions can fall in the same clock. The first is a push, single or double, that must find room. The second is the final byte of the head word leaving, which frees a slot. The bench fills the four-entry buffer and then pushes exactly in the clock where the head word's last byte goes out, then checks that the flag stays low and the word appears after the others. It also double-pushes into a buffer with one slot left, then checks that the flag rises and that the byte stream ends after the first of the two words.

// File: rtl/trace_drain_fifo.sv
module trace_drain_fifo #(
  parameter bit         DEEP      = 1'b1,
  parameter int         DATA_W    = 32,
  parameter int         PORT_W    = 8,
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap0_vld,
  input  logic [DATA_W-1:0] cap0_data,
  input  logic              cap1_vld,
  input  logic [DATA_W-1:0] cap1_data,
  output logic [PORT_W-1:0] trace_out,
  output logic              core_stall,
  output logic              ovf_flag
);
  localparam int DEPTH   = DEEP ? 4 : 2;
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int SET_LVL = DEEP ? 3 : 2;
  localparam int REL_LVL = DEEP ? 2 : 1;
  localparam int BYTES   = DATA_W / PORT_W;
  localparam int IW      = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt, cnt_n;
  logic [IW-1:0]     idx;
  logic [CW:0]       space;
  logic              pop, acc0, acc1, drop, stall_n;
  logic [AW-1:0]     wa1;

  assign pop   = (cnt != '0) && (idx == IW'(BYTES - 1));
  assign space = (CW+1)'(DEPTH) - {1'b0, cnt} + (CW+1)'(pop);
  assign acc0  = cap0_vld && (space >= (CW+1)'(1));
  assign acc1  = cap1_vld && (space >= (cap0_vld ? (CW+1)'(2) : (CW+1)'(1)));
  assign drop  = (cap0_vld && !acc0) || (cap1_vld && !acc1);
  assign wa1   = wp + AW'(acc0);
  assign cnt_n = cnt + CW'(acc0) + CW'(acc1) - CW'(pop);

  always_comb begin
    if (core_stall) stall_n = (cnt_n > CW'(REL_LVL));
    else            stall_n = (cnt_n >= CW'(SET_LVL));
  end

  always_ff @(posedge clk) begin
    if (acc0) mem[wp]  <= cap0_data;
    if (acc1) mem[wa1] <= cap1_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp         <= '0;
      rp         <= '0;
      cnt        <= '0;
      idx        <= '0;
      core_stall <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      wp         <= wp + AW'(acc0) + AW'(acc1);
      cnt        <= cnt_n;
      core_stall <= stall_n;
      if (drop) ovf_flag <= 1'b1;
      if (cnt != '0) idx <= pop ? '0 : idx + IW'(1);
      if (pop) rp <= rp + AW'(1);
    end
  end

  assign trace_out = (cnt != '0) ? mem[rp][(BYTES - 1 - int'(idx)) * PORT_W +: PORT_W]
                                 : IDLE_BYTE;
endmodule

// File: rtl/trace_drain_fifo_chk.sv
module trace_drain_fifo_chk #(
  parameter int         DEPTH     = 4,
  parameter int         CW        = 3,
  parameter int         SET_LVL   = 3,
  parameter int         REL_LVL   = 2,
  parameter int         PORT_W    = 8,
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     cnt,
  input logic              core_stall,
  input logic              ovf_flag,
  input logic              cap0_vld,
  input logic              cap1_vld,
  input logic [PORT_W-1:0] trace_out
);
  // R5 and R7: occupancy at the set level implies the stall request
  p_stall_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) >= SET_LVL) |-> core_stall);

  // R6 and R7: enough free slots implies no stall request
  p_stall_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) <= REL_LVL) |-> !core_stall);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(cap0_vld || cap1_vld));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (trace_out == IDLE_BYTE));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= int'($past(cnt)) + 2);
endmodule

bind trace_drain_fifo trace_drain_fifo_chk #(
  .DEPTH(DEPTH), .CW(CW), .SET_LVL(SET_LVL), .REL_LVL(REL_LVL),
  .PORT_W(PORT_W), .IDLE_BYTE(IDLE_BYTE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .core_stall(core_stall),
  .ovf_flag(ovf_flag), .cap0_vld(cap0_vld), .cap1_vld(cap1_vld),
  .trace_out(trace_out)
);

// File: tb/tb_trace_drain_fifo.sv
module tb_trace_drain_fifo;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] IDLE = 8'hFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c0v = 1'b0, c1v = 1'b0, s0v = 1'b0;
  logic [31:0] c0d = '0, c1d = '0, s0d = '0;
  logic [7:0]  tro, tro_s;
  logic        stl, stl_s, ovf, ovf_s;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_drain_fifo #(.DEEP(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cap0_vld(c0v), .cap0_data(c0d),
    .cap1_vld(c1v), .cap1_data(c1d), .trace_out(tro),
    .core_stall(stl), .ovf_flag(ovf));

  trace_drain_fifo #(.DEEP(1'b0)) dut_sh (
    .clk(clk), .rst_n(rst_n), .cap0_vld(s0v), .cap0_data(s0d),
    .cap1_vld(1'b0), .cap1_data(32'h0), .trace_out(tro_s),
    .core_stall(stl_s), .ovf_flag(ovf_s));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    c0v = 1'b0; c1v = 1'b0; s0v = 1'b0;
  endtask

  task automatic drive(input logic v0, input logic [31:0] d0,
                       input logic v1, input logic [31:0] d1);
    c0v = v0; c0d = d0; c1v = v1; c1d = d1;
  endtask

  task automatic nb(input string req, input logic [7:0] exp);
    @(negedge clk);
    clear_in();
    chk(req, {24'h0, tro}, {24'h0, exp});
  endtask

  task automatic nbs(input string req, input logic [7:0] exp);
    @(negedge clk);
    clear_in();
    chk(req, {24'h0, tro_s}, {24'h0, exp});
  endtask

  task automatic word_out(input string req, input logic [31:0] w);
    for (int i = 0; i < 4; i++) nb(req, w[31-8*i -: 8]);
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_in();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle in reset", {24'h0, tro}, {24'h0, IDLE});
    chk("R1 stall in reset", {31'h0, stl}, 32'h0);
    chk("R1 ovf in reset", {31'h0, ovf}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {24'h0, tro}, {24'h0, IDLE});
    chk("R1 shallow stall after reset", {31'h0, stl_s}, 32'h0);
    chk("R2 shallow idle", {24'h0, tro_s}, {24'h0, IDLE});
  endtask

  task automatic t_single();
    do_reset();
    drive(1'b1, 32'h11223344, 1'b0, 32'h0);
    word_out("R3 byte order", 32'h11223344);
    nb("R2 idle after drain", IDLE);
    nb("R2 idle stays", IDLE);
  endtask

  task automatic t_dual();
    do_reset();
    drive(1'b1, 32'hA0A1A2A3, 1'b1, 32'hB0B1B2B3);
    word_out("R4 strobe0 first", 32'hA0A1A2A3);
    word_out("R4 strobe1 second", 32'hB0B1B2B3);
    nb("R3 idle after two words", IDLE);
  endtask

  task automatic t_stall_deep();
    do_reset();
    drive(1'b1, 32'hC0C1C2C3, 1'b1, 32'hD0D1D2D3);
    nb("R3 C byte3", 8'hC0);
    chk("R5 no stall at two", {31'h0, stl}, 32'h0);
    drive(1'b1, 32'hE0E1E2E3, 1'b0, 32'h0);
    nb("R3 C byte2", 8'hC1);
    chk("R5 stall at three", {31'h0, stl}, 32'h1);
    nb("R3 C byte1", 8'hC2);
    chk("R5 stall holds", {31'h0, stl}, 32'h1);
    nb("R3 C byte0", 8'hC3);
    chk("R5 stall holds before pop", {31'h0, stl}, 32'h1);
    nb("R3 D byte3", 8'hD0);
    chk("R6 stall released at two", {31'h0, stl}, 32'h0);
    nb("R3 D byte2", 8'hD1);
    nb("R3 D byte1", 8'hD2);
    nb("R3 D byte0", 8'hD3);
    word_out("R4 E last", 32'hE0E1E2E3);
    nb("R2 idle", IDLE);
    chk("R8 no overflow under stall", {31'h0, ovf}, 32'h0);
  endtask

  task automatic t_overflow();
    do_reset();
    drive(1'b1, 32'h10203040, 1'b1, 32'h11213141);
    nb("R8 F0 byte3", 8'h10);
    drive(1'b1, 32'h12223242, 1'b1, 32'h13233343);
    nb("R8 F0 byte2", 8'h20);
    chk("R5 stall when full", {31'h0, stl}, 32'h1);
    chk("R8 no ovf yet", {31'h0, ovf}, 32'h0);
    drive(1'b1, 32'h55555555, 1'b0, 32'h0);
    nb("R8 F0 byte1", 8'h30);
    chk("R8 ovf set by push into full", {31'h0, ovf}, 32'h1);
    nb("R8 F0 byte0", 8'h40);
    word_out("R8 F1 intact", 32'h11213141);
    word_out("R8 F2 intact", 32'h12223242);
    word_out("R8 F3 intact", 32'h13233343);
    nb("R8 dropped word absent", IDLE);
    chk("R8 ovf sticky", {31'h0, ovf}, 32'h1);
  endtask

  task automatic t_same_cycle_free();
    do_reset();
    drive(1'b1, 32'h60616263, 1'b1, 32'h64656667);
    nb("R10 G0 byte3", 8'h60);
    drive(1'b1, 32'h68696A6B, 1'b1, 32'h6C6D6E6F);
    nb("R10 G0 byte2", 8'h61);
    nb("R10 G0 byte1", 8'h62);
    nb("R10 G0 byte0", 8'h63);
    drive(1'b1, 32'h70717273, 1'b0, 32'h0);
    nb("R10 G1 byte3", 8'h64);
    chk("R10 no ovf on freed slot", {31'h0, ovf}, 32'h1 & 32'h0);
    chk("R5 still stalled at four", {31'h0, stl}, 32'h1);
    nb("R10 G1 byte2", 8'h65);
    nb("R10 G1 byte1", 8'h66);
    nb("R10 G1 byte0", 8'h67);
    word_out("R10 G2", 32'h68696A6B);
    word_out("R10 G3", 32'h6C6D6E6F);
    word_out("R10 G4 accepted", 32'h70717273);
    nb("R10 idle after G4", IDLE);
  endtask

  task automatic t_partial();
    do_reset();
    drive(1'b1, 32'h80818283, 1'b1, 32'h84858687);
    nb("R9 H0 byte3", 8'h80);
    drive(1'b1, 32'h88898A8B, 1'b0, 32'h0);
    nb("R9 H0 byte2", 8'h81);
    drive(1'b1, 32'h90919293, 1'b1, 32'h94959697);
    nb("R9 H0 byte1", 8'h82);
    chk("R9 ovf from strobe1 drop", {31'h0, ovf}, 32'h1);
    nb("R9 H0 byte0", 8'h83);
    word_out("R9 H1", 32'h84858687);
    word_out("R9 H2", 32'h88898A8B);
    word_out("R9 H3 kept", 32'h90919293);
    nb("R9 H4 discarded", IDLE);
  endtask

  task automatic t_shallow();
    do_reset();
    s0v = 1'b1; s0d = 32'hA1B2C3D4;
    nbs("R3 shallow S0 byte3", 8'hA1);
    chk("R7 no stall at one", {31'h0, stl_s}, 32'h0);
    s0v = 1'b1; s0d = 32'h5A6B7C8D;
    nbs("R3 shallow S0 byte2", 8'hB2);
    chk("R7 stall when both full", {31'h0, stl_s}, 32'h1);
    nbs("R3 shallow S0 byte1", 8'hC3);
    nbs("R3 shallow S0 byte0", 8'hD4);
    chk("R7 stall holds", {31'h0, stl_s}, 32'h1);
    nbs("R4 shallow S1 byte3", 8'h5A);
    chk("R7 stall released at one free", {31'h0, stl_s}, 32'h0);
    nbs("R4 shallow S1 byte2", 8'h6B);
    nbs("R4 shallow S1 byte1", 8'h7C);
    nbs("R4 shallow S1 byte0", 8'h8D);
    nbs("R2 shallow idle", IDLE);
    chk("R8 shallow no ovf", {31'h0, ovf_s}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_dual();
    t_stall_deep();
    t_overflow();
    t_same_cycle_free();
    t_partial();
    t_shallow();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule